// File: doc/BRIEF.md
# Segment LCD Common-Phase Timing Generator

This block derives the common-line phase sequence of a segment LCD driver from a slow reference clock. The clock first passes through a power-of-two prescaler (16, 32, 64 or 128). A second stage then divides it by a programmable factor of 1 to 8. Each pulse from that chain is a slot tick. Slot ticks step a common-line index through the number of commons the duty setting asks for, and a phase polarity bit follows the selected waveform family. In bit-inversion mode the polarity flips inside every common slot. In frame-inversion mode it flips once per frame.

Each frame boundary produces a one-clock frame-start pulse. A frame tick marks the start of a frame with positive polarity, which is the point where display-memory update logic can safely swap in new contents. The configuration is copied into the generator only while it is idle or at a frame boundary, so a frame that has started always completes with the settings it began with. All pins are plain control and status levels: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The timing runs only while the block is enabled. In standby it runs only if run-in-standby is set.

Top module: `lcd_com_timing`

## Requirements
- R1: When `enable` is low, or `standby` is high while `run_in_stby` is low, the block is idle. On the next clock `com_idx` is 0, `phase_pol` is 0 and both pulses are 0, and they stay that way while idle. While idle, the configuration inputs are copied continuously.
- R2: While running, slot ticks occur every (16 << `presc_sel`) × (`clk_div` + 1) clocks. The first tick falls that many clocks after the first running clock edge.
- R3: `duty_sel` codes 0,1,2,3,4,5 give 1,2,3,4,6,8 commons, and the reserved codes 6 and 7 give 1 common. `com_idx` counts up from 0 to commons−1 and then wraps to 0.
- R4: When `wave_sel`=1 (bit inversion), each common slot lasts two slot ticks. `phase_pol` is 0 for the first tick and 1 for the second.
- R5: When `wave_sel`=0 (frame inversion), each common slot lasts one slot tick. `phase_pol` is constant within a frame and inverts at every frame boundary.
- R6: `frame_start` is high for exactly one clock, in the clock in which `com_idx` has just returned to 0 after the last slot of a frame.
- R7: `frame_tick` is high only together with `frame_start`, and only when the new frame starts with `phase_pol`=0. It fires every frame in bit-inversion mode and every second frame in frame-inversion mode.
- R8: A change to `presc_sel`, `clk_div`, `duty_sel` or `wave_sel` during a running frame does not affect that frame. The new values take effect from the next frame boundary.
- R9: With `standby` high and `run_in_stby` high, the timing continues exactly as when not in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Timing enable |
| standby | input | 1 | Chip is in standby sleep |
| run_in_stby | input | 1 | Keep running during standby |
| presc_sel | input | 2 | Prescaler code: divide by 16 << code |
| clk_div | input | 3 | Extra division minus one |
| duty_sel | input | 3 | Number-of-commons code |
| wave_sel | input | 1 | 1 = bit inversion, 0 = frame inversion |
| com_idx | output | 3 | Active common line |
| phase_pol | output | 1 | Drive polarity of the current phase |
| frame_start | output | 1 | One-clock pulse at each frame start |
| frame_tick | output | 1 | Pulse at the start of each positive-polarity frame |

## Verification
The embedded properties take for granted that the base prescale factor is at least two. With that, two frame boundaries can never fall on adjacent clocks. They also assume the configuration pins are only sampled at the edges where the generator copies them. Neither assumption depends on when the inputs change. The stimulus keeps the default prescale base and drives all inputs on the falling edge. It changes configuration both while idle and in the middle of a running frame, which exercises the boundary-only copy.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int PRESC_W = 2;
  localparam int DIV_W   = 3;
  localparam int DUTY_W  = 3;
  localparam int IDX_W   = 3;
  localparam int NCOM_W  = IDX_W + 1;

  typedef enum logic {
    WAVE_FRAME_INV = 1'b0,
    WAVE_BIT_INV   = 1'b1
  } wave_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [DIV_W-1:0]   ckdiv;
    logic [DUTY_W-1:0]  duty;
    wave_e              wave;
  } lcdt_cfg_t;

  function automatic logic [NCOM_W-1:0] commons_of(input logic [DUTY_W-1:0] code);
    case (code)
      3'd1:    commons_of = NCOM_W'(2);
      3'd2:    commons_of = NCOM_W'(3);
      3'd3:    commons_of = NCOM_W'(4);
      3'd4:    commons_of = NCOM_W'(6);
      3'd5:    commons_of = NCOM_W'(8);
      default: commons_of = NCOM_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv
  import lcdt_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DIV_W-1:0]   ckdiv,
  output logic               tick
);
  localparam int PCNT_W = BASE_LOG2 + (1 << PRESC_W) - 1;

  logic [PCNT_W-1:0] pre_q;
  logic [PCNT_W-1:0] pre_max;
  logic [DIV_W-1:0]  div_q;
  logic              pre_wrap;

  always_comb begin
    pre_max = '0;
    for (int i = 0; i < PCNT_W; i++) begin
      if (i < BASE_LOG2 + int'(presc)) pre_max[i] = 1'b1;
    end
  end

  assign pre_wrap = (pre_q == pre_max);
  assign tick     = run && pre_wrap && (div_q == ckdiv);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      div_q <= (div_q == ckdiv) ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_max);
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= ckdiv);
endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  lcdt_cfg_t        cfg_in,
  output lcdt_cfg_t        cfg_q,
  output logic [IDX_W-1:0] com_idx,
  output logic             phase_pol,
  output logic             frame_start,
  output logic             frame_tick
);
  logic [IDX_W-1:0]  com_q;
  logic [NCOM_W-1:0] ncom;
  logic              half_q;
  logic              fpar_q;
  logic              last_slot;
  logic              boundary;

  assign ncom      = commons_of(cfg_q.duty);
  assign last_slot = (NCOM_W'(com_q) == ncom - 1'b1) &&
                     ((cfg_q.wave == WAVE_FRAME_INV) || half_q);
  assign boundary  = tick && last_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      com_q       <= '0;
      half_q      <= 1'b0;
      fpar_q      <= 1'b0;
      frame_start <= 1'b0;
      frame_tick  <= 1'b0;
      cfg_q       <= '0;
    end else if (!run) begin
      com_q       <= '0;
      half_q      <= 1'b0;
      fpar_q      <= 1'b0;
      frame_start <= 1'b0;
      frame_tick  <= 1'b0;
      cfg_q       <= cfg_in;
    end else begin
      frame_start <= 1'b0;
      frame_tick  <= 1'b0;
      if (boundary) begin
        com_q       <= '0;
        half_q      <= 1'b0;
        cfg_q       <= cfg_in;
        frame_start <= 1'b1;
        if (cfg_in.wave == WAVE_FRAME_INV) begin
          fpar_q     <= ~fpar_q;
          frame_tick <= fpar_q;
        end else begin
          fpar_q     <= 1'b0;
          frame_tick <= 1'b1;
        end
      end else if (tick) begin
        if (cfg_q.wave == WAVE_BIT_INV && !half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          com_q  <= com_q + 1'b1;
        end
      end
    end
  end

  assign com_idx   = com_q;
  assign phase_pol = (cfg_q.wave == WAVE_BIT_INV) ? half_q : fpar_q;

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    NCOM_W'(com_q) < ncom);
  assert_pol_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase_pol));
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> $stable(cfg_q));
  assert_fs_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_fs_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (com_q == '0));
  assert_ft_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> (frame_start && !phase_pol));
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
  import lcdt_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               standby,
  input  logic               run_in_stby,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [DUTY_W-1:0]  duty_sel,
  input  logic               wave_sel,
  output logic [IDX_W-1:0]   com_idx,
  output logic               phase_pol,
  output logic               frame_start,
  output logic               frame_tick
);
  logic      run;
  logic      tick;
  lcdt_cfg_t cfg_in;
  lcdt_cfg_t cfg_q;

  assign run          = enable && (!standby || run_in_stby);
  assign cfg_in.presc = presc_sel;
  assign cfg_in.ckdiv = clk_div;
  assign cfg_in.duty  = duty_sel;
  assign cfg_in.wave  = wave_e'(wave_sel);

  lcdt_clkdiv #(.BASE_LOG2(BASE_LOG2)) u_clkdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .presc (cfg_q.presc),
    .ckdiv (cfg_q.ckdiv),
    .tick  (tick)
  );

  lcdt_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .tick        (tick),
    .cfg_in      (cfg_in),
    .cfg_q       (cfg_q),
    .com_idx     (com_idx),
    .phase_pol   (phase_pol),
    .frame_start (frame_start),
    .frame_tick  (frame_tick)
  );

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (com_idx == '0 && !phase_pol && !frame_start && !frame_tick));
endmodule

// File: tb/lcd_com_timing_bench.sv
module lcd_com_timing_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, standby = 1'b0, run_in_stby = 1'b0;
  logic [1:0] presc_sel = '0;
  logic [2:0] clk_div = '0, duty_sel = '0;
  logic       wave_sel = 1'b0;
  logic [2:0] com_idx;
  logic       phase_pol, frame_start, frame_tick;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  lcd_com_timing u_lcd_com_timing (
    .clk(clk), .rst_n(rst_n), .enable(enable), .standby(standby),
    .run_in_stby(run_in_stby), .presc_sel(presc_sel), .clk_div(clk_div),
    .duty_sel(duty_sel), .wave_sel(wave_sel), .com_idx(com_idx),
    .phase_pol(phase_pol), .frame_start(frame_start), .frame_tick(frame_tick)
  );

  function automatic int commons(input int code);
    case (code)
      1: return 2; 2: return 3; 3: return 4; 4: return 6; 5: return 8;
      default: return 1;
    endcase
  endfunction

  // Behavioural reference: clocks elapsed in the current frame
  int m_cnt = 0, m_par = 0, m_pr = 0, m_ck = 0, m_du = 0, m_wv = 0;
  bit m_fs = 0, m_ft = 0;

  function automatic int per_tick();
    return (16 << m_pr) * (m_ck + 1);
  endfunction
  function automatic int ticks_per_slot();
    return (m_wv != 0) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_par = 0; m_fs = 0; m_ft = 0;
      m_pr = 0; m_ck = 0; m_du = 0; m_wv = 0;
    end else if (!(enable && (!standby || run_in_stby))) begin
      m_cnt = 0; m_par = 0; m_fs = 0; m_ft = 0;
      m_pr = presc_sel; m_ck = clk_div; m_du = duty_sel; m_wv = wave_sel;
    end else begin
      m_fs = 0; m_ft = 0;
      m_cnt++;
      if (m_cnt == commons(m_du) * ticks_per_slot() * per_tick()) begin
        m_cnt = 0;
        m_pr = presc_sel; m_ck = clk_div; m_du = duty_sel; m_wv = wave_sel;
        m_par = (m_wv == 0) ? 1 - m_par : 0;
        m_fs = 1;
        m_ft = (m_par == 0);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference (R3 index, R4/R5 polarity, R6, R7)
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 com_idx", com_idx, m_cnt / (ticks_per_slot() * per_tick()));
      chk((m_wv != 0) ? "R4 phase_pol" : "R5 phase_pol", phase_pol,
          (m_wv != 0) ? (m_cnt / per_tick()) % 2 : m_par);
      chk("R6 frame_start", frame_start, m_fs);
      chk("R7 frame_tick", frame_tick, m_ft);
    end
  end

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic frame_len(output int n);
    wait_fs();
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
  endtask

  task automatic set_cfg(input int p, input int c, input int d, input int w);
    presc_sel = 2'(p); clk_div = 3'(c); duty_sel = 3'(d); wave_sel = 1'(w);
  endtask

  initial begin
    int n, mx, cnt, pol_a;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset com_idx", com_idx, 0);
    chk("R1 reset phase_pol", phase_pol, 0);
    chk("R1 reset frame_start", frame_start, 0);
    rst_n = 1'b1;
    cmp_en = 1;

    // R4 bit inversion, 4 commons, tick every 16 clocks
    set_cfg(0, 0, 3, 1); @(negedge clk); enable = 1'b1;
    frame_len(n); chk("R4 frame length 4 commons", n, 128);
    wait_fs();
    repeat (5) @(negedge clk);  chk("R4 first half polarity", phase_pol, 0);
    repeat (15) @(negedge clk); chk("R4 second half polarity", phase_pol, 1);
    cnt = 0;
    for (int f = 0; f < 4; f++) begin wait_fs(); cnt += frame_tick; end
    chk("R7 ticks per 4 frames bit-inv", cnt, 4);

    // R5 frame inversion, 3 commons, prescale 32, divide 3
    enable = 1'b0; @(negedge clk);
    set_cfg(1, 2, 2, 0); @(negedge clk); enable = 1'b1;
    frame_len(n); chk("R5 frame length 3 commons", n, 288);
    pol_a = phase_pol; wait_fs();
    chk("R5 polarity inverts per frame", phase_pol, 1 - pol_a);
    cnt = 0;
    for (int f = 0; f < 4; f++) begin wait_fs(); cnt += frame_tick; end
    chk("R7 ticks per 4 frames frame-inv", cnt, 2);

    // R2 slot tick period: one common, frame inversion => one tick per frame
    enable = 1'b0; @(negedge clk);
    set_cfg(2, 1, 0, 0); @(negedge clk); enable = 1'b1;
    frame_len(n); chk("R2 period 64x2", n, 128);
    enable = 1'b0; @(negedge clk);
    set_cfg(3, 7, 0, 0); @(negedge clk); enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
    chk("R2 first tick after enable 128x8", n, 1024);

    // R3 six and eight commons, reserved codes
    enable = 1'b0; @(negedge clk);
    set_cfg(0, 0, 4, 1); @(negedge clk); enable = 1'b1;
    frame_len(n); chk("R3 six commons frame", n, 192);
    enable = 1'b0; @(negedge clk);
    set_cfg(0, 0, 5, 0); @(negedge clk); enable = 1'b1;
    wait_fs(); mx = 0;
    do begin @(negedge clk); if (com_idx > mx) mx = com_idx; end while (!frame_start);
    chk("R3 eight commons top index", mx, 7);
    for (int code = 6; code < 8; code++) begin
      enable = 1'b0; @(negedge clk);
      set_cfg(0, 0, code, 1); @(negedge clk); enable = 1'b1;
      wait_fs(); mx = 0;
      do begin @(negedge clk); if (com_idx > mx) mx = com_idx; end while (!frame_start);
      chk("R3 reserved duty gives one common", mx, 0);
    end

    // R8 change mid-frame
    enable = 1'b0; @(negedge clk);
    set_cfg(0, 0, 1, 1); @(negedge clk); enable = 1'b1;
    wait_fs(); repeat (10) @(negedge clk);
    duty_sel = 3'd3;
    n = 10;
    do begin @(negedge clk); n++; end while (!frame_start);
    chk("R8 running frame keeps old duty", n, 64);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
    chk("R8 next frame uses new duty", n, 128);

    // R9 standby with run-in-standby
    standby = 1'b1; run_in_stby = 1'b1;
    frame_len(n); chk("R9 runs in standby", n, 128);

    // R1 standby without run-in-standby, then enable low
    run_in_stby = 1'b0;
    repeat (40) begin
      @(negedge clk);
      chk("R1 standby idle com", com_idx, 0);
      chk("R1 standby idle pulse", frame_start, 0);
    end
    standby = 1'b0; run_in_stby = 1'b0;
    repeat (70) @(negedge clk);
    enable = 1'b0;
    repeat (40) begin
      @(negedge clk);
      chk("R1 disabled idle com", com_idx, 0);
      chk("R1 disabled idle pol", phase_pol, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule